// File: doc/BRIEF.md
# Segmented Flash Program/Erase Controller

This block holds a behavioural model of an embedded flash array and puts a command-driven controller in front of it. A CPU-side request bus carries one operation per request. The operation is a read, a program of one byte or one aligned word, or one of three erase kinds: one segment, all of main memory, or everything. The array is modelled with registers inside the block. After an erase, every location reads as all ones. A program can only turn ones into zeros.

There are two segment sizes in a single 16-bit byte address space. Main memory consists of 512-byte segments and ends at 0xFFFF. Segment 0 is the top one, and segment numbers count upward toward lower addresses. Information memory is two 128-byte segments. Segment B is at 0x1000–0x107F and segment A is at 0x1080–0x10FF.

Each accepted program or erase raises `busy` for a fixed, parameterised number of cycles. Any request made while busy is dropped and flagged. A level lock input blocks all modifying commands while it is high.

Top module: `segflash_ctrl`

## Requirements
- R1: After synchronous reset, every mapped byte reads 0xFF, and `busy`, `viol` and `rvalid` are low.
- R2: A read (op 0) is answered in the next cycle with `rvalid` high. `rdata` holds the aligned word: the byte at the even address is in bits 7:0 and the byte at the odd address is in bits 15:8. Address bit 0 is ignored. Unmapped addresses read 0x0000.
- R3: A byte program (op 1) stores the old byte AND `wdata[7:0]`, so bits are only ever cleared.
- R4: A word program (op 2) at an even address ANDs `wdata[7:0]` into the even byte and `wdata[15:8]` into the odd byte. At an odd address it is rejected with a violation and changes nothing.
- R5: A segment erase (op 3) sets to 0xFF the 512-byte main segment, or the 128-byte information segment, that holds the address. Main segment 0 is 0xFE00–0xFFFF. Information segment B is 0x1000–0x107F and A is 0x1080–0x10FF. No other byte changes.
- R6: A main erase (op 4) sets every main byte to 0xFF and leaves both information segments unchanged. The address is ignored.
- R7: A full erase (op 5) sets every main and information byte to 0xFF.
- R8: An accepted modifying command holds `busy` high, starting in the cycle after acceptance, for PROG_CYCLES cycles (ops 1, 2), SEG_CYCLES cycles (op 3) or MASS_CYCLES cycles (ops 4, 5). Reads never raise `busy`.
- R9: Any request made while `busy` is high is ignored, and `viol` pulses high for one cycle in the next cycle.
- R10: While `lock` is high, ops 1 to 5 are rejected with a `viol` pulse and no effect. Reads still work.
- R11: These requests are rejected with a `viol` pulse and no effect: a program or segment erase to an unmapped address, and op codes 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock | input | 1 | High blocks program and erase commands |
| req | input | 1 | Request strobe, one operation per cycle |
| op | input | 3 | Operation code: 0 read, 1 byte program, 2 word program, 3 segment erase, 4 main erase, 5 full erase |
| addr | input | 16 | Byte address |
| wdata | input | 16 | Program data |
| rdata | output | 16 | Read word, valid when rvalid |
| rvalid | output | 1 | Read answer strobe |
| busy | output | 1 | Operation in progress |
| viol | output | 1 | One-cycle pulse for a rejected request |

## Verification
The bench targets the boundary between the two information segments. An off-by-one mask there would wipe segment B when segment A is erased. It also targets main segment 0 at the top of the address space, where a wrong segment base would erase a neighbouring segment or miss the vector area. Two kinds of program are exercised on purpose. A repeated program of the same byte shows whether the design overwrites instead of ANDing. A word program at an odd address shows whether the design silently stores misaligned data. Requests issued during the busy window and under lock are followed by reads of the targeted bytes. A design that let them through would show changed data or a shortened busy window, and the cycle-by-cycle comparison of `busy` catches wrong cycle counts for each operation kind.

// File: rtl/segflash_pkg.sv
package segflash_pkg;

    localparam int ADDR_W         = 16;
    localparam int DATA_W         = 16;
    localparam int IDX_W          = 17;
    localparam int MAIN_SEG_BYTES = 512;
    localparam int INFO_SEG_BYTES = 128;
    localparam int INFO_SEGS      = 2;
    localparam int INFO_BYTES     = INFO_SEG_BYTES * INFO_SEGS;
    localparam int INFO_BASE      = 4096;

    typedef enum logic [2:0] {
        OP_READ       = 3'd0,
        OP_PROG_BYTE  = 3'd1,
        OP_PROG_WORD  = 3'd2,
        OP_ERASE_SEG  = 3'd3,
        OP_ERASE_MAIN = 3'd4,
        OP_ERASE_ALL  = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        RG_NONE,
        RG_INFO,
        RG_MAIN
    } region_e;

    typedef enum logic [1:0] {
        ER_NONE,
        ER_RANGE,
        ER_MAIN,
        ER_ALL
    } erase_e;

    typedef struct packed {
        region_e          region;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] first;
        logic [IDX_W-1:0] last;
    } loc_t;

    typedef struct packed {
        logic              prog;
        logic              word;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
        erase_e            erase;
        logic [IDX_W-1:0]  first;
        logic [IDX_W-1:0]  last;
    } cmd_t;

    function automatic logic is_modify(input logic [2:0] op);
        return (op >= 3'd1) && (op <= 3'd5);
    endfunction

    function automatic logic needs_target(input logic [2:0] op);
        return (op == 3'd1) || (op == 3'd2) || (op == 3'd3);
    endfunction

    function automatic logic is_program(input logic [2:0] op);
        return (op == 3'd1) || (op == 3'd2);
    endfunction

endpackage

// File: rtl/segflash_decode.sv
module segflash_decode
    import segflash_pkg::*;
#(
    parameter int MAIN_SEGS = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output loc_t              loc
);
    localparam int MAIN_BYTES = MAIN_SEGS * MAIN_SEG_BYTES;
    localparam int MAIN_BASE  = 65536 - MAIN_BYTES;

    localparam logic [IDX_W-1:0] BASE_X     = IDX_W'(MAIN_BASE);
    localparam logic [IDX_W-1:0] INFO_X     = IDX_W'(INFO_BASE);
    localparam logic [IDX_W-1:0] INFO_END_X = IDX_W'(INFO_BASE + INFO_BYTES);
    localparam logic [IDX_W-1:0] INFO_N     = IDX_W'(INFO_BYTES);
    localparam logic [IDX_W-1:0] IMASK      = IDX_W'(INFO_SEG_BYTES - 1);
    localparam logic [IDX_W-1:0] MMASK      = IDX_W'(MAIN_SEG_BYTES - 1);

    logic [IDX_W-1:0] ax;
    logic [IDX_W-1:0] moff;
    logic [IDX_W-1:0] ioff;

    always_comb begin
        ax   = IDX_W'(addr);
        moff = ax - BASE_X;
        ioff = ax - INFO_X;
        loc  = '0;
        loc.region = RG_NONE;
        if ((ax >= INFO_X) && (ax < INFO_END_X)) begin
            loc.region = RG_INFO;
            loc.idx    = ioff;
            loc.first  = ioff & ~IMASK;
            loc.last   = (ioff & ~IMASK) | IMASK;
        end else if (ax >= BASE_X) begin
            loc.region = RG_MAIN;
            loc.idx    = INFO_N + moff;
            loc.first  = INFO_N + (moff & ~MMASK);
            loc.last   = INFO_N + ((moff & ~MMASK) | MMASK);
        end
    end

endmodule

// File: rtl/segflash_seq.sv
module segflash_seq
    import segflash_pkg::*;
#(
    parameter int PROG_CYCLES = 3,
    parameter int SEG_CYCLES  = 8,
    parameter int MASS_CYCLES = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  logic [2:0] op,
    input  logic       lock,
    input  region_e    region,
    input  logic       addr_lsb,
    output logic       busy,
    output logic       viol,
    output logic       go_read,
    output logic       go_write
);
    localparam int MAX_A = (PROG_CYCLES > SEG_CYCLES) ? PROG_CYCLES : SEG_CYCLES;
    localparam int MAX_C = (MAX_A > MASS_CYCLES) ? MAX_A : MASS_CYCLES;
    localparam int CNT_W = $clog2(MAX_C + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] load_val;
    logic             reject;

    assign busy = (cnt != '0);

    always_comb begin
        reject = req && (busy
                      || (op > 3'd5)
                      || (is_modify(op) && lock)
                      || ((op == 3'd2) && addr_lsb)
                      || (needs_target(op) && (region == RG_NONE)));
        go_read  = req && !reject && (op == 3'd0);
        go_write = req && !reject && is_modify(op);
        if (is_program(op)) begin
            load_val = CNT_W'(PROG_CYCLES);
        end else if (op == 3'd3) begin
            load_val = CNT_W'(SEG_CYCLES);
        end else begin
            load_val = CNT_W'(MASS_CYCLES);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            viol <= 1'b0;
        end else begin
            viol <= reject;
            if (go_write) begin
                cnt <= load_val;
            end else if (busy) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // R9: request during busy is flagged next cycle
    a_r9_busy_req_flagged: assert property (@(posedge clk) disable iff (rst)
        (req && busy) |=> viol);

    // R10: locked modify commands are flagged
    a_r10_lock_flagged: assert property (@(posedge clk) disable iff (rst)
        (req && lock && is_modify(op)) |=> viol);

    // R8: an accepted command makes the block busy next cycle
    a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        go_write |=> busy);

    // R8: busy only begins because of an accepted command
    a_r8_busy_rise_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(go_write));

endmodule

// File: rtl/segflash_array.sv
module segflash_array
    import segflash_pkg::*;
#(
    parameter int DEPTH = 1280
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              cmd,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              rd_mapped,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    localparam int AW = $clog2(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] rd_lo;
    logic [AW-1:0] rd_hi;
    logic [AW-1:0] pg_lo;
    logic [AW-1:0] pg_hi;
    logic [AW-1:0] first_a;

    assign rd_lo   = rd_idx[AW-1:0];
    assign rd_hi   = rd_idx[AW-1:0] + 1'b1;
    assign pg_lo   = cmd.idx[AW-1:0];
    assign pg_hi   = cmd.idx[AW-1:0] + 1'b1;
    assign first_a = cmd.first[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= 8'hFF;
            end
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= rd_en;
            if (rd_en) begin
                rdata <= rd_mapped ? {mem[rd_hi], mem[rd_lo]} : '0;
            end
            for (int i = 0; i < DEPTH; i++) begin
                case (cmd.erase)
                    ER_RANGE: if ((IDX_W'(i) >= cmd.first) && (IDX_W'(i) <= cmd.last)) mem[i] <= 8'hFF;
                    ER_MAIN:  if (i >= INFO_BYTES) mem[i] <= 8'hFF;
                    ER_ALL:   mem[i] <= 8'hFF;
                    default:  ;
                endcase
            end
            if (cmd.prog) begin
                mem[pg_lo] <= mem[pg_lo] & cmd.data[7:0];
                if (cmd.word) begin
                    mem[pg_hi] <= mem[pg_hi] & cmd.data[15:8];
                end
            end
        end
    end

    // R5: the first byte of an erased segment is blank afterwards
    a_r5_range_blank: assert property (@(posedge clk) disable iff (rst)
        (cmd.erase == ER_RANGE) |=> (mem[$past(first_a)] == 8'hFF));

endmodule

// File: rtl/segflash_ctrl.sv
module segflash_ctrl
    import segflash_pkg::*;
#(
    parameter int MAIN_SEGS   = 2,
    parameter int PROG_CYCLES = 3,
    parameter int SEG_CYCLES  = 8,
    parameter int MASS_CYCLES = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        lock,
    input  logic        req,
    input  logic [2:0]  op,
    input  logic [15:0] addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic        rvalid,
    output logic        busy,
    output logic        viol
);
    localparam int DEPTH = INFO_BYTES + MAIN_SEGS * MAIN_SEG_BYTES;

    loc_t             loc;
    cmd_t             cmd;
    logic             go_read;
    logic             go_write;
    logic [IDX_W-1:0] rd_idx;

    segflash_decode #(.MAIN_SEGS(MAIN_SEGS)) u_decode (
        .addr (addr),
        .loc  (loc)
    );

    segflash_seq #(
        .PROG_CYCLES (PROG_CYCLES),
        .SEG_CYCLES  (SEG_CYCLES),
        .MASS_CYCLES (MASS_CYCLES)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .op       (op),
        .lock     (lock),
        .region   (loc.region),
        .addr_lsb (addr[0]),
        .busy     (busy),
        .viol     (viol),
        .go_read  (go_read),
        .go_write (go_write)
    );

    always_comb begin
        cmd       = '0;
        cmd.erase = ER_NONE;
        cmd.prog  = go_write && is_program(op);
        cmd.word  = (op == 3'd2);
        cmd.idx   = loc.idx;
        cmd.data  = wdata;
        cmd.first = loc.first;
        cmd.last  = loc.last;
        if (go_write) begin
            case (op)
                3'd3:    cmd.erase = ER_RANGE;
                3'd4:    cmd.erase = ER_MAIN;
                3'd5:    cmd.erase = ER_ALL;
                default: cmd.erase = ER_NONE;
            endcase
        end
    end

    assign rd_idx = loc.idx & ~IDX_W'(1);

    segflash_array #(.DEPTH(DEPTH)) u_array (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .rd_en     (go_read),
        .rd_idx    (rd_idx),
        .rd_mapped (loc.region != RG_NONE),
        .rdata     (rdata),
        .rvalid    (rvalid)
    );

    // R2: a read answer and a rejection never share a cycle
    a_r2_answer_not_rejected: assert property (@(posedge clk) disable iff (rst)
        !(rvalid && viol));

    // R2: a read answer follows a request one cycle earlier
    a_r2_answer_has_request: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> ($past(req) && ($past(op) == 3'd0)));

endmodule

// File: tb/segflash_ctrl_bench.sv
`timescale 1ns/1ps
module segflash_ctrl_bench;

    localparam int MAIN_SEGS = 2;
    localparam int PROG_C    = 3;
    localparam int SEG_C     = 8;
    localparam int MASS_C    = 12;
    localparam int MAIN_BASE = 65536 - MAIN_SEGS * 512;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lock = 1'b0;
    logic        req = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [15:0] addr = 16'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        rvalid;
    logic        busy;
    logic        viol;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0] mm [int];
    int         mcnt = 0;
    logic       e_viol = 0;
    logic       e_rv = 0;
    logic [15:0] e_rd = 0;

    always #2 clk = ~clk;

    segflash_ctrl #(
        .MAIN_SEGS(MAIN_SEGS), .PROG_CYCLES(PROG_C),
        .SEG_CYCLES(SEG_C), .MASS_CYCLES(MASS_C)
    ) u_segflash_ctrl (
        .clk(clk), .rst(rst), .lock(lock), .req(req), .op(op),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
        .busy(busy), .viol(viol)
    );

    function automatic bit is_info(int a);
        return (a >= 32'h1000) && (a < 32'h1100);
    endfunction

    function automatic bit is_mapped(int a);
        return is_info(a) || (a >= MAIN_BASE);
    endfunction

    function automatic logic [7:0] rb(int a);
        return mm.exists(a) ? mm[a] : 8'hFF;
    endfunction

    task automatic blank(int lo, int hi);
        for (int a = lo; a <= hi; a++) begin
            if (mm.exists(a)) mm.delete(a);
        end
    endtask

    task automatic model(bit r, int o, int a, logic [15:0] d);
        bit was_busy;
        bit wr;
        was_busy = (mcnt != 0);
        if (mcnt != 0) mcnt--;
        e_viol = 0;
        e_rv   = 0;
        if (r) begin
            wr = (o >= 1) && (o <= 5);
            if (was_busy || o > 5 || (wr && lock) || (o == 2 && a[0]) ||
                ((o >= 1 && o <= 3) && !is_mapped(a))) begin
                e_viol = 1;
            end else begin
                case (o)
                    0: begin
                        e_rv = 1;
                        e_rd = is_mapped(a) ? {rb(a | 1), rb(a & ~1)} : 16'h0000;
                    end
                    1: begin mm[a] = rb(a) & d[7:0]; mcnt = PROG_C; end
                    2: begin
                        mm[a]     = rb(a) & d[7:0];
                        mm[a + 1] = rb(a + 1) & d[15:8];
                        mcnt = PROG_C;
                    end
                    3: begin
                        if (is_info(a)) blank(a & ~127, (a & ~127) + 127);
                        else blank(a & ~511, (a & ~511) + 511);
                        mcnt = SEG_C;
                    end
                    4: begin blank(MAIN_BASE, 65535); mcnt = MASS_C; end
                    default: begin
                        blank(MAIN_BASE, 65535);
                        blank(32'h1000, 32'h10FF);
                        mcnt = MASS_C;
                    end
                endcase
            end
        end
    endtask

    task automatic step(bit r, int o, int a, logic [15:0] d, string tag);
        req   = r;
        op    = 3'(o);
        addr  = 16'(a);
        wdata = d;
        @(posedge clk);
        model(r, o, a, d);
        @(negedge clk);
        checks++;
        if (busy !== (mcnt != 0) || viol !== e_viol || rvalid !== e_rv ||
            (e_rv && rdata !== e_rd)) begin
            fails++;
            $display("FAIL %s: busy/viol/rvalid/rdata got %b/%b/%b/%h expected %b/%b/%b/%h",
                     tag, busy, viol, rvalid, rdata, (mcnt != 0), e_viol, e_rv, e_rd);
        end
        req = 1'b0;
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 16'h0, tag);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        mm.delete();
        mcnt = 0;
        // R1: reset state and blank array
        idle(1, "R1");
        step(1, 0, 16'hFFFE, 0, "R1");
        step(1, 0, 16'h1000, 0, "R1");
        step(1, 0, 16'h10FE, 0, "R1");
        step(1, 0, MAIN_BASE, 0, "R1");
        // R3: byte program ANDs, repeated program clears more bits
        step(1, 1, 16'hFFFE, 16'h005A, "R3");
        idle(PROG_C, "R8");
        step(1, 0, 16'hFFFE, 0, "R3");
        step(1, 1, 16'hFFFE, 16'h000F, "R3");
        idle(PROG_C, "R8");
        step(1, 0, 16'hFFFF, 0, "R2");
        // R4: word program and odd-address rejection
        step(1, 2, 16'hFC10, 16'h1234, "R4");
        idle(PROG_C, "R8");
        step(1, 0, 16'hFC11, 0, "R2");
        step(1, 2, 16'hFC11, 16'h0000, "R4");
        step(1, 0, 16'hFC10, 0, "R4");
        step(1, 0, 16'hFC12, 0, "R4");
        // R9: requests during busy are dropped
        step(1, 1, 16'h1000, 16'h0000, "R9");
        step(1, 0, 16'h1000, 0, "R9");
        step(1, 1, 16'h1002, 16'h0000, "R9");
        idle(PROG_C, "R9");
        step(1, 0, 16'h1002, 0, "R9");
        // R8: a read does not raise busy; next command accepted at once
        step(1, 0, 16'h1000, 0, "R8");
        step(1, 2, 16'h1080, 16'h0000, "R8");
        idle(PROG_C, "R8");
        // R10: lock rejects modifications, reads still allowed
        lock = 1'b1;
        step(1, 1, 16'hFC20, 16'h0000, "R10");
        step(1, 5, 16'h0000, 0, "R10");
        step(1, 3, 16'h1000, 0, "R10");
        step(1, 0, 16'hFC20, 0, "R10");
        step(1, 0, 16'h1000, 0, "R10");
        lock = 1'b0;
        // R11: unmapped targets and bad op codes
        step(1, 1, 16'h2000, 16'h0000, "R11");
        step(1, 3, 16'h0000, 0, "R11");
        step(1, 6, 16'hFC10, 0, "R11");
        step(1, 7, 16'hFC10, 0, "R11");
        step(1, 0, 16'h2000, 0, "R11");
        step(1, 0, 16'hFC10, 0, "R11");
        // R5: info segment A erase keeps B
        step(1, 3, 16'h10A3, 0, "R5");
        idle(SEG_C, "R8");
        step(1, 0, 16'h1080, 0, "R5");
        step(1, 0, 16'h1000, 0, "R5");
        // R5: main segment 0 erase keeps the segment below it
        step(1, 3, 16'hFF13, 0, "R5");
        idle(SEG_C, "R8");
        step(1, 0, 16'hFFFE, 0, "R5");
        step(1, 0, 16'hFE00, 0, "R5");
        step(1, 0, 16'hFC10, 0, "R5");
        // R6: main erase keeps information memory
        step(1, 1, 16'hFE00, 16'h0000, "R6");
        idle(PROG_C, "R6");
        step(1, 4, 16'h1234, 0, "R6");
        idle(MASS_C, "R8");
        step(1, 0, 16'hFC10, 0, "R6");
        step(1, 0, 16'hFE00, 0, "R6");
        step(1, 0, 16'h1000, 0, "R6");
        // R7: full erase clears both kinds
        step(1, 2, 16'hFDFE, 16'h0F0F, "R7");
        idle(PROG_C, "R7");
        step(1, 5, 16'h0000, 0, "R7");
        idle(MASS_C, "R8");
        step(1, 0, 16'h1000, 0, "R7");
        step(1, 0, 16'hFDFE, 0, "R7");
        idle(2, "R1");
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule